// File: doc/BRIEF.md
# Hold-and-Load Debug Controller

This controller sits between a host serial link and a small soft processor. From reset it keeps the processor halted. The host can then fill program memory, preset processor registers (for example the stack pointer in register 2) and finally release the processor at a chosen fetch address. Host traffic arrives as bytes from an external UART receiver. Replies leave through an external UART transmitter, and the processor also uses that transmitter. The controller owns the byte-level multiplexer in front of the transmitter. The processor drives the line until the first valid debug frame arrives; from then on the controller drives it.

A frame is a sync byte, an opcode, a four-byte address, an optional four-byte data word and a checksum byte. Accepted commands cause one-cycle strobes on the memory port or the register-write port, or a one-cycle start strobe to the processor. Each accepted frame is answered over the serial line. When the processor signals that its program has finished, it drops back into hold, so the host can read results out of memory. A hold command or a synchronous reset hands the transmitter back to the processor once the reply in flight has fully left.

Top module: `hold_load_ctrl`

## Requirements
- R1: After `rst_n` is released, `cpu_hold` is 1, `cpu_start` is 0 and `dbg_owns_tx` is 0.
- R2: While `dbg_owns_tx` is 0, `tx_valid` and `tx_byte` copy `cpu_tx_valid` and `cpu_tx_byte`, and `cpu_tx_ready` copies `tx_ready`.
- R3: Frame layout:
  - The first byte is the sync byte 0x5A, followed by one opcode byte.
  - Opcode values: 0x01 memory write, 0x02 memory read, 0x03 register write, 0x04 start, 0x05 hold.
  - Next come four address bytes, most significant first.
  - Opcodes 0x01 and 0x03 then carry four data bytes, most significant first.
  - The last byte is the checksum: the XOR of the opcode, address and data bytes.
  - A frame with a correct checksum sets `dbg_owns_tx` to 1 in the cycle after its checksum byte.
  - Reply bytes are offered on `tx_valid`/`tx_byte` and held until `tx_ready` takes them.
- R4: A frame is dropped if its checksum is wrong or its opcode is outside 0x01..0x05. A dropped frame produces no reply and no strobe, and leaves `dbg_owns_tx` unchanged.
- R5: An accepted memory write in hold gives one `mem_we` cycle with the frame's address and data, and a reply of 0x01.
- R6: An accepted memory read in hold gives one `mem_re` cycle. After `mem_rvalid`, the reply is 0x02 followed by the four bytes of `mem_rdata`, most significant first.
- R7: An accepted register write in hold gives one `reg_we` cycle, with `reg_addr` equal to the low address bits and `reg_wdata` equal to the data word, and a reply of 0x03.
- R8: An accepted start in hold gives a `cpu_start` strobe exactly one cycle wide, with `cpu_start_addr` equal to the frame address. `cpu_hold` drops in that same cycle, and the reply is 0x04.
- R9: While the processor runs, start, memory write, memory read and register write frames cause no strobe and are answered with 0xEE.
- R10: A `cpu_done` pulse returns `cpu_hold` to 1, after which memory reads work again.
- R11: If no byte arrives for `TIMEOUT` (default 65535) clock cycles partway through a frame, the parser goes back to waiting for a sync byte.
- R12: A hold command sets `cpu_hold` and is answered with 0x05. `dbg_owns_tx` stays 1 until that reply byte has been taken and `tx_ready` is high again, and then it returns to 0.
- R13: `soft_rst` puts the processor in hold and resets the parser. Any reply in flight is still sent, and only after that does `dbg_owns_tx` return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous reset into hold |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| tx_ready | input | 1 | Transmitter idle and able to take a byte |
| tx_valid | output | 1 | Byte offered to the transmitter |
| tx_byte | output | 8 | Byte to the transmitter |
| cpu_tx_valid | input | 1 | Processor byte request |
| cpu_tx_byte | input | 8 | Processor byte |
| cpu_tx_ready | output | 1 | Transmitter ready as seen by the processor |
| dbg_owns_tx | output | 1 | Controller drives the transmitter |
| cpu_hold | output | 1 | Processor halted |
| cpu_start | output | 1 | One-cycle release strobe |
| cpu_start_addr | output | AW | First fetch address |
| cpu_done | input | 1 | Processor reports program end |
| reg_we | output | 1 | Register write strobe |
| reg_addr | output | RAW | Register index |
| reg_wdata | output | DW | Register value |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| mem_rvalid | input | 1 | Read data valid |

## Verification
The assertions assume a few things about the inputs:
- The transmitter takes a byte only in a cycle where `tx_ready` is high.
- `mem_rvalid` comes back once for each `mem_re`.
- The host waits for a reply before it starts the next frame.

The stimulus keeps within these limits. The bench's memory model answers one cycle after each read strobe. Its transmitter model stays busy for a few cycles after every byte it takes. The frame driver waits until all expected reply bytes have been seen before it sends the next frame.

// File: rtl/hold_load_ctrl.sv
module hold_load_ctrl #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int RAW = 5,
  parameter int TIMEOUT = 65535,
  parameter logic [7:0] SYNC = 8'h5A,
  parameter logic [7:0] ERR = 8'hEE
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           soft_rst,
  input  logic           rx_valid,
  input  logic [7:0]     rx_byte,
  input  logic           tx_ready,
  output logic           tx_valid,
  output logic [7:0]     tx_byte,
  input  logic           cpu_tx_valid,
  input  logic [7:0]     cpu_tx_byte,
  output logic           cpu_tx_ready,
  output logic           dbg_owns_tx,
  output logic           cpu_hold,
  output logic           cpu_start,
  output logic [AW-1:0]  cpu_start_addr,
  input  logic           cpu_done,
  output logic           reg_we,
  output logic [RAW-1:0] reg_addr,
  output logic [DW-1:0]  reg_wdata,
  output logic           mem_re,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           mem_rvalid
);
  localparam int ANB = AW / 8;
  localparam int DNB = DW / 8;
  localparam int BCW = $clog2((ANB > DNB ? ANB : DNB) + 1);
  localparam int QN  = 1 + DNB;
  localparam int QW  = 8 + DW;
  localparam int QCW = $clog2(QN + 1);
  localparam int TW  = $clog2(TIMEOUT + 1);
  localparam logic [7:0] OP_MWR = 8'h01, OP_MRD = 8'h02, OP_RWR = 8'h03,
                         OP_GO  = 8'h04, OP_HLD = 8'h05;

  typedef enum logic [2:0] {S_SYNC, S_OP, S_ADDR, S_DATA, S_SUM} pst_t;

  pst_t           st;
  logic [7:0]     op_q, sum_q;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  data_q;
  logic [BCW-1:0] bcnt;
  logic [TW-1:0]  idle_cnt;
  logic           own, rel_pend, running, rd_wait;
  logic [QW-1:0]  q_sh;
  logic [QCW-1:0] q_cnt;

  wire busy     = rd_wait || mem_re || (q_cnt != '0);
  wire frame_ok = rx_valid && !soft_rst && (st == S_SUM) && (rx_byte == sum_q) && !busy;
  wire deq      = (q_cnt != '0) && tx_ready;
  wire op_known = (rx_byte >= OP_MWR) && (rx_byte <= OP_HLD);
  wire has_data = (op_q == OP_MWR) || (op_q == OP_RWR);

  assign dbg_owns_tx  = own;
  assign cpu_hold     = !running;
  assign tx_valid     = own ? (q_cnt != '0) : cpu_tx_valid;
  assign tx_byte      = own ? q_sh[QW-1 -: 8] : cpu_tx_byte;
  assign cpu_tx_ready = !own && tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_SYNC; op_q <= '0; sum_q <= '0; addr_q <= '0; data_q <= '0;
      bcnt <= '0; idle_cnt <= '0;
    end else if (soft_rst) begin
      st <= S_SYNC; idle_cnt <= '0;
    end else if (rx_valid) begin
      idle_cnt <= '0;
      case (st)
        S_SYNC: if (rx_byte == SYNC) st <= S_OP;
        S_OP: begin
          if (op_known) begin
            op_q <= rx_byte; sum_q <= rx_byte; bcnt <= '0; st <= S_ADDR;
          end else st <= S_SYNC;
        end
        S_ADDR: begin
          addr_q <= {addr_q[AW-9:0], rx_byte};
          sum_q  <= sum_q ^ rx_byte;
          if (bcnt == BCW'(ANB - 1)) begin
            bcnt <= '0;
            st   <= has_data ? S_DATA : S_SUM;
          end else bcnt <= bcnt + 1'b1;
        end
        S_DATA: begin
          data_q <= {data_q[DW-9:0], rx_byte};
          sum_q  <= sum_q ^ rx_byte;
          if (bcnt == BCW'(DNB - 1)) begin
            bcnt <= '0; st <= S_SUM;
          end else bcnt <= bcnt + 1'b1;
        end
        default: st <= S_SYNC;
      endcase
    end else if (st != S_SYNC) begin
      if (idle_cnt == TW'(TIMEOUT - 1)) begin
        st <= S_SYNC; idle_cnt <= '0;
      end else idle_cnt <= idle_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own <= 1'b0; rel_pend <= 1'b0; running <= 1'b0; rd_wait <= 1'b0;
      q_sh <= '0; q_cnt <= '0;
      cpu_start <= 1'b0; cpu_start_addr <= '0;
      reg_we <= 1'b0; reg_addr <= '0; reg_wdata <= '0;
      mem_re <= 1'b0; mem_we <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
    end else begin
      cpu_start <= 1'b0; reg_we <= 1'b0; mem_re <= 1'b0; mem_we <= 1'b0;
      if (deq) begin
        q_sh  <= q_sh << 8;
        q_cnt <= q_cnt - 1'b1;
      end
      if (rd_wait && mem_rvalid) begin
        q_sh <= {OP_MRD, mem_rdata}; q_cnt <= QCW'(QN); rd_wait <= 1'b0;
      end
      if (cpu_done) running <= 1'b0;
      if (rel_pend && q_cnt == '0 && !rd_wait && tx_ready) begin
        own <= 1'b0; rel_pend <= 1'b0;
      end
      if (soft_rst) begin
        running <= 1'b0; rel_pend <= own;
      end
      if (frame_ok) begin
        own <= 1'b1; rel_pend <= 1'b0;
        q_cnt <= QCW'(1);
        q_sh  <= {op_q, {DW{1'b0}}};
        if (running && op_q != OP_HLD) begin
          q_sh <= {ERR, {DW{1'b0}}};
        end else begin
          case (op_q)
            OP_MWR: begin mem_we <= 1'b1; mem_addr <= addr_q; mem_wdata <= data_q; end
            OP_MRD: begin mem_re <= 1'b1; mem_addr <= addr_q; rd_wait <= 1'b1; q_cnt <= '0; end
            OP_RWR: begin reg_we <= 1'b1; reg_addr <= addr_q[RAW-1:0]; reg_wdata <= data_q; end
            OP_GO:  begin cpu_start <= 1'b1; cpu_start_addr <= addr_q; running <= 1'b1; end
            default: begin running <= 1'b0; rel_pend <= 1'b1; end
          endcase
        end
      end
    end
  end

  p_start_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_start |=> !cpu_start);
  p_start_from_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_start |-> ($past(cpu_hold) && !cpu_hold));
  p_access_in_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re || reg_we) |-> cpu_hold);
  p_reply_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (own && q_cnt != '0 && !tx_ready) |=> (q_cnt == $past(q_cnt) && $stable(q_sh)));
  p_gain_on_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(own) |-> $past(frame_ok));
  p_release_after_reply_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(own) |-> ($past(q_cnt) == '0 && $past(tx_ready)));
endmodule

// File: tb/tb_hold_load_ctrl.sv
`timescale 1ns/1ps
module tb_hold_load_ctrl;
  localparam int TO = 40;
  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0;
  logic rx_valid = 1'b0; logic [7:0] rx_byte = '0;
  logic tx_ready, tx_valid; logic [7:0] tx_byte;
  logic cpu_tx_valid = 1'b0; logic [7:0] cpu_tx_byte = '0; logic cpu_tx_ready;
  logic dbg_owns_tx, cpu_hold, cpu_start, cpu_done = 1'b0;
  logic [31:0] cpu_start_addr;
  logic reg_we; logic [4:0] reg_addr; logic [31:0] reg_wdata;
  logic mem_re, mem_we, mem_rvalid = 1'b0; logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;

  always #2.5 clk = ~clk;

  hold_load_ctrl #(.TIMEOUT(TO)) dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .cpu_tx_valid(cpu_tx_valid), .cpu_tx_byte(cpu_tx_byte), .cpu_tx_ready(cpu_tx_ready),
    .dbg_owns_tx(dbg_owns_tx), .cpu_hold(cpu_hold), .cpu_start(cpu_start),
    .cpu_start_addr(cpu_start_addr), .cpu_done(cpu_done), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .mem_re(mem_re), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid));

  int checks = 0, errors = 0;
  byte unsigned exp_q[$];
  string tag_q[$];
  logic [31:0] mem [16];
  int tbusy = 0;
  int n_start = 0, n_memwe = 0, n_regwe = 0;
  logic prev_start = 1'b0;
  logic [31:0] last_start_addr = '0;
  logic [4:0] exp_ra = '0; logic [31:0] exp_rd = '0;

  assign tx_ready = (tbusy == 0);

  always @(posedge clk) begin
    if (tbusy != 0) tbusy <= tbusy - 1;
    else if (tx_valid) tbusy <= 3;
    mem_rvalid <= mem_re;
    if (mem_re) mem_rdata <= mem[mem_addr[5:2]];
    if (mem_we) mem[mem_addr[5:2]] <= mem_wdata;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && dbg_owns_tx && tx_valid && tx_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R3 unexpected reply byte", {24'h0, tx_byte}, 32'h0);
      else begin
        automatic byte unsigned e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(tx_byte == e, t, {24'h0, tx_byte}, {24'h0, e});
      end
    end
    if (rst_n && cpu_start) begin
      n_start++;
      last_start_addr = cpu_start_addr;
      if (prev_start) chk(1'b0, "R8 start wider than one cycle", 32'd2, 32'd1);
    end
    prev_start = cpu_start;
    if (rst_n && mem_we) n_memwe++;
    if (rst_n && reg_we) begin
      n_regwe++;
      chk(reg_addr == exp_ra && reg_wdata == exp_rd, "R7 register write", reg_wdata, exp_rd);
    end
  end

  task automatic push(input byte unsigned b, input string t);
    exp_q.push_back(b); tag_q.push_back(t);
  endtask

  task automatic push_word(input byte unsigned op, input logic [31:0] w, input string t);
    push(op, t);
    for (int i = 3; i >= 0; i--) push(w[i*8 +: 8], t);
  endtask

  task automatic send_byte(input logic [7:0] b);
    repeat (2) @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic send_frame(input logic [7:0] op, input logic [31:0] a, input logic [31:0] d, input bit bad);
    logic [7:0] s;
    s = op;
    send_byte(8'h5A); send_byte(op);
    for (int i = 3; i >= 0; i--) begin send_byte(a[i*8 +: 8]); s ^= a[i*8 +: 8]; end
    if (op == 8'h01 || op == 8'h03)
      for (int i = 3; i >= 0; i--) begin send_byte(d[i*8 +: 8]); s ^= d[i*8 +: 8]; end
    send_byte(bad ? ~s : s);
  endtask

  task automatic drain(input string t);
    int w = 0;
    while (exp_q.size() != 0 && w < 500) begin @(negedge clk); w++; end
    repeat (8) @(negedge clk);
    if (w >= 500) chk(1'b0, t, exp_q.size(), 0);
  endtask

  bit done = 1'b0;
  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    cpu_tx_valid = 1'b1; cpu_tx_byte = 8'h41;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_hold == 1'b1, "R1 hold after reset", cpu_hold, 1);
    chk(cpu_start == 1'b0 && dbg_owns_tx == 1'b0, "R1 no start, no ownership", {cpu_start, dbg_owns_tx}, 0);
    chk(tx_valid == 1'b1 && tx_byte == 8'h41, "R2 processor drives tx", {tx_valid, tx_byte}, {1'b1, 8'h41});
    chk(cpu_tx_ready == tx_ready, "R2 ready passes through", cpu_tx_ready, tx_ready);
    cpu_tx_valid = 1'b0;
    repeat (8) @(negedge clk);

    send_frame(8'h01, 32'h10, 32'hDEADBEEF, 1'b1);
    drain("R4 bad checksum");
    chk(dbg_owns_tx == 1'b0 && n_memwe == 0, "R4 bad checksum dropped", {dbg_owns_tx, n_memwe[7:0]}, 0);
    send_byte(8'h5A); send_byte(8'h07);
    for (int i = 0; i < 5; i++) send_byte(8'h11);
    drain("R4 unknown opcode");
    chk(dbg_owns_tx == 1'b0, "R4 unknown opcode dropped", dbg_owns_tx, 0);

    push(8'h01, "R5 write reply");
    send_frame(8'h01, 32'h10, 32'hDEADBEEF, 1'b0);
    drain("R5 write reply missing");
    chk(dbg_owns_tx == 1'b1, "R3 ownership gained", dbg_owns_tx, 1);
    chk(n_memwe == 1 && mem[4] == 32'hDEADBEEF, "R5 memory written", mem[4], 32'hDEADBEEF);

    push_word(8'h02, 32'hDEADBEEF, "R6 read reply");
    send_frame(8'h02, 32'h10, 32'h0, 1'b0);
    drain("R6 read reply missing");

    exp_ra = 5'd2; exp_rd = 32'h00001FF0;
    push(8'h03, "R7 reg reply");
    send_frame(8'h03, 32'h2, 32'h00001FF0, 1'b0);
    drain("R7 reg reply missing");
    chk(n_regwe == 1, "R7 one register strobe", n_regwe, 1);

    push(8'h04, "R8 start reply");
    send_frame(8'h04, 32'h80, 32'h0, 1'b0);
    drain("R8 start reply missing");
    chk(n_start == 1 && last_start_addr == 32'h80, "R8 start address", last_start_addr, 32'h80);
    chk(cpu_hold == 1'b0, "R8 processor released", cpu_hold, 0);

    push(8'hEE, "R9 start while running");
    send_frame(8'h04, 32'h100, 32'h0, 1'b0);
    push(8'hEE, "R9 write while running");
    send_frame(8'h01, 32'h14, 32'h1234, 1'b0);
    drain("R9 error reply missing");
    chk(n_start == 1 && n_memwe == 1, "R9 no action while running", n_start, 1);

    @(negedge clk); cpu_done = 1'b1; @(negedge clk); cpu_done = 1'b0;
    @(negedge clk);
    chk(cpu_hold == 1'b1, "R10 back in hold", cpu_hold, 1);
    push_word(8'h02, 32'h0, "R10 read after done");
    send_frame(8'h02, 32'h14, 32'h0, 1'b0);
    drain("R10 read reply missing");

    send_byte(8'h5A); send_byte(8'h01); send_byte(8'h00); send_byte(8'h00);
    repeat (TO + 5) @(negedge clk);
    push_word(8'h02, 32'hDEADBEEF, "R11 frame after timeout");
    send_frame(8'h02, 32'h10, 32'h0, 1'b0);
    drain("R11 parser not resynchronised");

    push(8'h05, "R12 hold reply");
    send_frame(8'h05, 32'h0, 32'h0, 1'b0);
    chk(dbg_owns_tx == 1'b1, "R12 kept while reply pending", dbg_owns_tx, 1);
    drain("R12 hold reply missing");
    chk(dbg_owns_tx == 1'b0 && cpu_hold == 1'b1, "R12 ownership returned", {dbg_owns_tx, cpu_hold}, 1);
    cpu_tx_valid = 1'b1; cpu_tx_byte = 8'h42;
    @(negedge clk);
    chk(tx_valid == 1'b1 && tx_byte == 8'h42, "R12 processor drives tx again", tx_byte, 8'h42);
    cpu_tx_valid = 1'b0;
    repeat (8) @(negedge clk);

    push(8'h04, "R13 start reply");
    send_frame(8'h04, 32'h200, 32'h0, 1'b0);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk(dbg_owns_tx == 1'b1, "R13 kept until reply sent", dbg_owns_tx, 1);
    drain("R13 reply missing");
    chk(dbg_owns_tx == 1'b0 && cpu_hold == 1'b1, "R13 hold and release", {dbg_owns_tx, cpu_hold}, 1);
    chk(n_start == 2 && last_start_addr == 32'h200, "R8 second start", last_start_addr, 32'h200);

    chk(exp_q.size() == 0, "R3 all replies seen", exp_q.size(), 0);
    finish_run();
  end
endmodule